// File: doc/BRIEF.md
# Interrupt Bus Message Status Evaluator

This block sits on the sending side of a two-wire serial bus that carries interrupt messages. Once a message is launched it counts the bus cycles, captures the two-bit status flags the receivers drive in the checksum status cycle and in the acceptance status cycle, and from those two captures decides the fate of the message. It reports whether the arbitration identifier must be advanced, whether the message was taken, and whether it has to be sent again.

The delivery mode of the message sets how long it runs. End-of-interrupt messages are short and every other mode uses the long form. The mode also sets the cycle in which the arbitration update is signalled, which is always the cycle before the last. The surrounding sender supplies a start strobe, the mode, the raw bus sample each cycle, and a strobe for each of the two status cycles. It uses the verdict in the final cycle to decide whether to queue a resend. Arbitration itself, data serialization and checksum generation belong to other blocks.

Top module: `msg_status_eval`

## Requirements
- R1: A start accepted with `mode_i` equal to 3'b011 (end-of-interrupt) runs 14 bus cycles. Any other mode code runs 21 cycles. The cycle after the start strobe counts as cycle 1.
- R2: `done_o` is high for exactly one clock, in the last cycle of the message (cycle 14 or cycle 21).
- R3: `arb_upd_o` pulses for one clock in the cycle before the last (cycle 13 or cycle 20), and only when the checksum flags are 2'b00 and the acceptance flags are 2'b10 or 2'b11.
- R4: Checksum flags 2'b00 with acceptance flags 2'b10 give `accept_o`=1 and `retry_o`=0 in the final cycle, and the arbitration update is signalled.
- R5: Checksum flags 2'b00 with acceptance flags 2'b11 give `retry_o`=1 and `accept_o`=0, and the arbitration update is still signalled.
- R6: Checksum flags 2'b00 with acceptance flags 2'b00 or 2'b01 give `retry_o`=1 with no arbitration update.
- R7: Checksum flags 2'b01, 2'b10 or 2'b11 give `retry_o`=1 with no arbitration update, whatever the acceptance flags are.
- R8: If the strobe for either status cycle never arrives during a message, that status counts as an error: `retry_o`=1 and no arbitration update.
- R9: A status strobe is captured only in cycles 1 through length-2 of a running message, and a later strobe replaces an earlier one. Bus values outside the strobed cycles, such as the third status cycle, have no effect.
- R10: A start strobe while a message is running, including in its final cycle, is ignored. The running message keeps its length and its verdict.
- R11: A synchronous active-high `rst` returns the block to idle, drops all outputs in the next cycle, and abandons any message in progress without a done pulse.
- R12: `accept_o` and `retry_o` are both low whenever `done_o` is low. When `done_o` is high, exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch of a new outgoing message |
| mode_i | input | 3 | Delivery mode code, sampled with the start |
| bus_i | input | 2 | Two-wire bus sample for the current cycle |
| a_strobe_i | input | 1 | Marks the checksum status cycle |
| a1_strobe_i | input | 1 | Marks the acceptance status cycle |
| done_o | output | 1 | One-clock pulse in the last message cycle |
| retry_o | output | 1 | Resend required, valid with done_o |
| arb_upd_o | output | 1 | Arbitration ID update pulse |
| accept_o | output | 1 | Message accepted, valid with done_o |

## Verification
The assertions check on every cycle the cycle-level relations between the outputs. The done pulse lasts one clock, and the verdict flags appear only with it, one at a time. An update pulse is always followed by done. An accept always follows an update, and reset clears every output. Only the bench scenarios can show the decoding of particular flag values, the mode-dependent length, that late or missing strobes are handled, and that a restart during a message is ignored. For these, a behavioural model in the bench follows every message and compares all outputs each clock.

// File: rtl/msg_status_pkg.sv
package msg_status_pkg;

  typedef logic [1:0] flag_t;

  // checksum-cycle value that means the checksum was good
  localparam flag_t CSUM_GOOD   = 2'b00;
  // acceptance-cycle value that means the message was taken
  localparam flag_t ACPT_TAKEN  = 2'b10;

  // one captured status: whether its strobe arrived, and the value seen
  typedef struct packed {
    logic  seen;
    flag_t val;
  } capt_t;

  localparam int NUM_FLAGS = 2;
  localparam int FLG_CSUM  = 0;
  localparam int FLG_ACPT  = 1;

endpackage

// File: rtl/msg_cycle_counter.sv
module msg_cycle_counter #(
  parameter int MODE_W    = 3,
  parameter int EOI_CODE  = 3,
  parameter int SHORT_LEN = 14,
  parameter int LONG_LEN  = 21,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              launch_o,
  output logic              win_o,
  output logic              upd_cyc_o,
  output logic              pre_last_o
);

  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] upd_at;
  logic [CNT_W-1:0] pre_at;

  assign launch_o = start_i && !busy_q;
  assign upd_at   = len_q - TWO_C;
  assign pre_at   = len_q - ONE_C;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= LONG_C;
    end else if (launch_o) begin
      busy_q <= 1'b1;
      cnt_q  <= ONE_C;
      len_q  <= (mode_i == MODE_W'(EOI_CODE)) ? SHORT_C : LONG_C;
    end else if (busy_q) begin
      if (cnt_q == len_q) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + ONE_C;
      end
    end
  end

  assign win_o      = busy_q && (cnt_q <= upd_at);
  assign upd_cyc_o  = busy_q && (cnt_q == upd_at);
  assign pre_last_o = busy_q && (cnt_q == pre_at);

endmodule

// File: rtl/msg_flag_capture.sv
module msg_flag_capture
  import msg_status_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear_i,
  input  logic  win_i,
  input  logic  strobe_i,
  input  flag_t sample_i,
  output capt_t eff_o
);

  capt_t q;
  logic  take;

  assign take = win_i && strobe_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      q <= '0;
    end else if (take) begin
      q <= '{seen: 1'b1, val: sample_i};
    end
  end

  // a strobe in the current cycle is visible at once, so a strobe in the
  // update-decision cycle still counts
  assign eff_o = take ? '{seen: 1'b1, val: sample_i} : q;

endmodule

// File: rtl/msg_outcome.sv
module msg_outcome
  import msg_status_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  upd_cyc_i,
  input  logic  pre_last_i,
  input  capt_t csum_i,
  input  capt_t acpt_i,
  output logic  done_o,
  output logic  retry_o,
  output logic  arb_upd_o,
  output logic  accept_o
);

  logic csum_ok;
  logic wants_upd;
  logic taken;

  assign csum_ok   = csum_i.seen && (csum_i.val == CSUM_GOOD);
  assign wants_upd = csum_ok && acpt_i.seen && acpt_i.val[1];
  assign taken     = csum_ok && acpt_i.seen && (acpt_i.val == ACPT_TAKEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      retry_o   <= 1'b0;
      arb_upd_o <= 1'b0;
      accept_o  <= 1'b0;
    end else begin
      done_o    <= pre_last_i;
      accept_o  <= pre_last_i && taken;
      retry_o   <= pre_last_i && !taken;
      arb_upd_o <= upd_cyc_i && wants_upd;
    end
  end

endmodule

// File: rtl/msg_status_eval.sv
module msg_status_eval
  import msg_status_pkg::*;
#(
  parameter int MODE_W    = 3,
  parameter int EOI_CODE  = 3,
  parameter int SHORT_LEN = 14,
  parameter int LONG_LEN  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        bus_i,
  input  logic              a_strobe_i,
  input  logic              a1_strobe_i,
  output logic              done_o,
  output logic              retry_o,
  output logic              arb_upd_o,
  output logic              accept_o
);

  localparam int CNT_W = $clog2(LONG_LEN + 1);

  logic                 launch;
  logic                 win;
  logic                 upd_cyc;
  logic                 pre_last;
  logic [NUM_FLAGS-1:0] strobes;
  capt_t                eff [NUM_FLAGS];

  assign strobes[FLG_CSUM] = a_strobe_i;
  assign strobes[FLG_ACPT] = a1_strobe_i;

  msg_cycle_counter #(
    .MODE_W   (MODE_W),
    .EOI_CODE (EOI_CODE),
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .launch_o  (launch),
    .win_o     (win),
    .upd_cyc_o (upd_cyc),
    .pre_last_o(pre_last)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    msg_flag_capture u_cap (
      .clk     (clk),
      .rst     (rst),
      .clear_i (launch),
      .win_i   (win),
      .strobe_i(strobes[g]),
      .sample_i(bus_i),
      .eff_o   (eff[g])
    );
  end

  msg_outcome u_out (
    .clk       (clk),
    .rst       (rst),
    .upd_cyc_i (upd_cyc),
    .pre_last_i(pre_last),
    .csum_i    (eff[FLG_CSUM]),
    .acpt_i    (eff[FLG_ACPT]),
    .done_o    (done_o),
    .retry_o   (retry_o),
    .arb_upd_o (arb_upd_o),
    .accept_o  (accept_o)
  );

endmodule

// File: rtl/msg_status_eval_chk.sv
module msg_status_eval_chk (
  input logic clk,
  input logic rst,
  input logic done_o,
  input logic retry_o,
  input logic arb_upd_o,
  input logic accept_o
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R2

  AST_UPD_LEADS_DONE: assert property (@(posedge clk) disable iff (rst)
    arb_upd_o |=> done_o); // R3

  AST_UPD_APART_DONE: assert property (@(posedge clk) disable iff (rst)
    arb_upd_o |-> !done_o); // R3

  AST_ACCEPT_AFTER_UPD: assert property (@(posedge clk) disable iff (rst)
    (done_o && accept_o) |-> $past(arb_upd_o)); // R4

  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (!accept_o && !retry_o)); // R12

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $countones({accept_o, retry_o}) == 1); // R12

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!done_o && !arb_upd_o && !accept_o && !retry_o)); // R11

endmodule

bind msg_status_eval msg_status_eval_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .done_o   (done_o),
  .retry_o  (retry_o),
  .arb_upd_o(arb_upd_o),
  .accept_o (accept_o)
);

// File: tb/tb_msg_status_eval.sv
module tb_msg_status_eval;

  localparam logic [2:0] EOI = 3'b011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic [1:0] bus_i = 2'b11;
  logic       a_strobe_i = 1'b0;
  logic       a1_strobe_i = 1'b0;
  logic       done_o, retry_o, arb_upd_o, accept_o;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag = "R11";
  bit    model_on = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  msg_status_eval dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .bus_i(bus_i),
    .a_strobe_i(a_strobe_i), .a1_strobe_i(a1_strobe_i),
    .done_o(done_o), .retry_o(retry_o), .arb_upd_o(arb_upd_o), .accept_o(accept_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: message position and captured status values
  int       m_cyc = 0;
  int       m_len = 21;
  bit       m_has_a, m_has_a1;
  bit [1:0] m_a, m_a1;
  bit       e_done, e_upd, e_acc, e_ret;

  always @(posedge clk) begin
    if (rst) begin
      m_cyc = 0; e_done = 0; e_upd = 0; e_acc = 0; e_ret = 0;
    end else begin
      e_done = 0; e_upd = 0; e_acc = 0; e_ret = 0;
      if (m_cyc == 0) begin
        if (start_i) begin
          m_cyc = 1; m_len = (mode_i == EOI) ? 14 : 21;
          m_has_a = 0; m_has_a1 = 0;
        end
      end else begin
        if (m_cyc <= m_len - 2) begin
          if (a_strobe_i)  begin m_has_a = 1;  m_a = bus_i;  end
          if (a1_strobe_i) begin m_has_a1 = 1; m_a1 = bus_i; end
        end
        if (m_cyc == m_len - 2)
          e_upd = m_has_a && m_a == 2'b00 && m_has_a1 && (m_a1 == 2'b10 || m_a1 == 2'b11);
        if (m_cyc == m_len - 1) begin
          e_done = 1;
          e_acc  = m_has_a && m_a == 2'b00 && m_has_a1 && m_a1 == 2'b10;
          e_ret  = !e_acc;
        end
        if (m_cyc == m_len) m_cyc = 0; else m_cyc++;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(done_o == e_done, "R2", done_o, e_done);
      check(arb_upd_o == e_upd, "R3", arb_upd_o, e_upd);
      check(accept_o == e_acc, cur_tag, accept_o, e_acc);
      check(retry_o == e_ret, cur_tag, retry_o, e_ret);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 0; a_strobe_i = 0; a1_strobe_i = 0; bus_i = 2'b11;
    end
  endtask

  // a_cyc / a1_cyc = 0 means that strobe never comes
  task automatic run_msg(input logic [2:0] mode, input int a_cyc, input logic [1:0] a_v,
                         input int a1_cyc, input logic [1:0] a1_v, input bit late,
                         input bit restart, input string tag);
    int len;
    int seen;
    len = (mode == EOI) ? 14 : 21;
    seen = 0;
    cur_tag = tag;
    @(negedge clk);
    start_i = 1; mode_i = mode; a_strobe_i = 0; a1_strobe_i = 0; bus_i = 2'b11;
    for (int k = 1; k <= len + 1; k++) begin
      @(negedge clk);
      if (done_o && seen == 0) seen = k;
      start_i = restart && (k == 5 || k == len);
      mode_i = restart ? ~mode : mode;
      a_strobe_i = 0; a1_strobe_i = 0; bus_i = 2'b11;
      if (k == a_cyc) begin a_strobe_i = 1; bus_i = a_v; end
      if (k == a1_cyc) begin a1_strobe_i = 1; bus_i = a1_v; end
      if (late && k == len - 1) begin a_strobe_i = 1; a1_strobe_i = 1; bus_i = 2'b11; end
    end
    check(seen == len, {tag, "/R1 length"}, seen, len);
  endtask

  initial begin
    idle(3);
    check(done_o == 0 && retry_o == 0 && arb_upd_o == 0 && accept_o == 0,
          "R11 reset state", {done_o, retry_o, arb_upd_o, accept_o}, 0);
    rst = 0;
    model_on = 1;
    idle(2);
    run_msg(3'b000, 3, 2'b00, 6, 2'b10, 0, 0, "R4");
    run_msg(EOI,    2, 2'b00, 5, 2'b10, 0, 0, "R4");
    run_msg(3'b001, 4, 2'b00, 8, 2'b11, 0, 0, "R5");
    run_msg(EOI,    4, 2'b00, 8, 2'b11, 0, 0, "R5");
    run_msg(3'b010, 3, 2'b00, 6, 2'b00, 0, 0, "R6");
    run_msg(EOI,    3, 2'b00, 6, 2'b01, 0, 0, "R6");
    run_msg(3'b100, 3, 2'b11, 6, 2'b10, 0, 0, "R7");
    run_msg(3'b101, 3, 2'b10, 6, 2'b10, 0, 0, "R7");
    run_msg(EOI,    3, 2'b01, 6, 2'b11, 0, 0, "R7");
    run_msg(3'b110, 0, 2'b00, 6, 2'b10, 0, 0, "R8");
    run_msg(EOI,    3, 2'b00, 0, 2'b10, 0, 0, "R8");
    run_msg(3'b111, 3, 2'b00, 19, 2'b10, 1, 0, "R9");
    run_msg(EOI,    12, 2'b00, 12, 2'b10, 1, 0, "R9");
    run_msg(3'b000, 3, 2'b11, 6, 2'b01, 0, 0, "R9");
    run_msg(EOI,    3, 2'b00, 6, 2'b10, 0, 1, "R10");
    run_msg(3'b000, 3, 2'b00, 6, 2'b11, 0, 1, "R10");
    idle(3);
    // R9: a second strobe overwrites the first (error replaced by good)
    cur_tag = "R9";
    @(negedge clk); start_i = 1; mode_i = EOI;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      start_i = 0; a_strobe_i = 0; a1_strobe_i = 0; bus_i = 2'b11;
      if (k == 2) begin a_strobe_i = 1; bus_i = 2'b11; end
      if (k == 4) begin a_strobe_i = 1; bus_i = 2'b00; end
      if (k == 6) begin a1_strobe_i = 1; bus_i = 2'b10; end
      if (k == 14) check(accept_o == 1, "R9 overwrite", accept_o, 1);
    end
    // R11: reset in the middle of a message abandons it
    cur_tag = "R11";
    @(negedge clk); start_i = 1; mode_i = 3'b000;
    begin
      int dones;
      dones = 0;
      for (int k = 1; k <= 30; k++) begin
        @(negedge clk);
        start_i = 0; a_strobe_i = 0; a1_strobe_i = 0; bus_i = 2'b11;
        rst = (k == 6);
        if (k == 3) begin a_strobe_i = 1; bus_i = 2'b00; end
        if (k == 4) begin a1_strobe_i = 1; bus_i = 2'b10; end
        if (done_o || arb_upd_o) dones++;
      end
      check(dones == 0, "R11 abandoned message", dones, 0);
    end
    run_msg(EOI, 3, 2'b00, 6, 2'b10, 0, 0, "R4");
    idle(4);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule